// File: doc/BRIEF.md
# Vector Structure Interleave Permuter

This block rearranges packed elements spread across two, three or four consecutive 64-bit vector registers. In spread mode it takes a sequential stream of elements and deals them out round-robin: one element to each register in turn, filling lane 0 of every register, then lane 1, and so on. In gather mode it applies the exact inverse, collecting lane 0 of every register, then lane 1, back into a sequential stream. The element width can be 8, 16, 32 or 64 bits. A load path uses spread mode to turn an array of structures into separate register columns, and a store path uses gather mode to turn them back.

The source and result are 256-bit buses that hold up to four registers side by side. Each request is marked by `in_valid`. The permuted result is registered and appears with `out_valid` one clock later. Registers beyond the selected count read as zero in the result, and source bits beyond the selected count are ignored.

Top module: `vec_lace_permuter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid` and `out_data` are zero after that edge.
- R2: `out_valid` equals the value that `in_valid` had at the previous rising edge (one cycle of latency).
- R3: Register r occupies bits [64r+63:64r], made of two 32-bit words with the lower word in the less significant half. Element k of width E sits at bits [kE+E-1:kE]. With `in_mode`=0 (spread), source element k goes to register (k mod R), lane (k div R), where R is the register count.
- R4: With `in_mode`=1 (gather), result element k is taken from source register (k mod R), lane (k div R).
- R5: `in_esize` selects the element width: 0 for 8 bits, 1 for 16, 2 for 32, 3 for 64. Each register holds 64/E elements.
- R6: `in_nregs` gives the register count R, with legal values 2, 3 and 4. Any other value behaves exactly like 2.
- R7: Result bits above 64R are zero.
- R8: Source bits above 64R have no effect on the result.
- R9: While `in_valid` is low, `out_data` keeps its previous value.
- R10: Spreading and then gathering with the same width and count returns the original data in the low 64R bits, for all 12 combinations.
- R11: With 64-bit elements, both modes pass the selected registers through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 1 | 0 = spread, 1 = gather |
| in_esize | input | 2 | Element width code |
| in_nregs | input | 3 | Register count |
| in_data | input | 256 | Source registers, register 0 in the low bits |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_data | output | 256 | Permuted registers |

## Verification
Each result is due exactly one rising edge after the request is presented. The bench drives a request on a falling edge, drops `in_valid` on the next falling edge, and reads `out_valid` and `out_data` at that same point, which is after the single capturing edge. The latency check also samples `out_valid` just after the request is driven, before the edge, to confirm it is still low. The hold check keeps `in_valid` low for several cycles while changing the source and compares the output at each falling edge.

// File: rtl/lace_pkg.sv
package lace_pkg;

  typedef enum logic {
    LACE_SPREAD = 1'b0,
    LACE_GATHER = 1'b1
  } lace_mode_e;

  localparam int LACE_NUM_WIDTHS = 4;

  // width code -> element width in bits (8 << code)
  function automatic int lace_elem_bits(input int code);
    return 8 << code;
  endfunction

endpackage

// File: rtl/lace_perm_net.sv
// Fixed wiring for one element width and one register count; both modes.
module lace_perm_net #(
  parameter int ELEM_W   = 8,
  parameter int NREGS    = 2,
  parameter int REG_W    = 64,
  parameter int MAX_REGS = 4
) (
  input  logic [REG_W*MAX_REGS-1:0] data_i,
  output logic [REG_W*MAX_REGS-1:0] spread_o,
  output logic [REG_W*MAX_REGS-1:0] gather_o
);
  localparam int PER   = REG_W / ELEM_W;
  localparam int NELEM = NREGS * PER;
  localparam int USED  = NREGS * REG_W;
  localparam int DW    = REG_W * MAX_REGS;

  for (genvar k = 0; k < NELEM; k++) begin : g_elem
    localparam int SLOT = (k % NREGS) * PER + (k / NREGS);
    assign spread_o[SLOT*ELEM_W +: ELEM_W] = data_i[k*ELEM_W +: ELEM_W];
    assign gather_o[k*ELEM_W +: ELEM_W]    = data_i[SLOT*ELEM_W +: ELEM_W];
  end

  if (USED < DW) begin : g_pad
    logic unused_hi;
    assign unused_hi            = ^data_i[DW-1:USED];
    assign spread_o[DW-1:USED]  = '0;
    assign gather_o[DW-1:USED]  = '0;
  end

endmodule

// File: rtl/lace_perm_bank.sv
// All width/count variants side by side, then a mux picks one.
module lace_perm_bank
  import lace_pkg::*;
#(
  parameter int REG_W    = 64,
  parameter int MAX_REGS = 4
) (
  input  logic [REG_W*MAX_REGS-1:0] data_i,
  input  lace_mode_e                mode_i,
  input  logic [1:0]                size_i,
  input  logic [1:0]                cnt_idx_i,
  output logic [REG_W*MAX_REGS-1:0] perm_o
);
  localparam int DW   = REG_W * MAX_REGS;
  localparam int NCNT = MAX_REGS - 1;

  logic [DW-1:0] spread_c [LACE_NUM_WIDTHS][NCNT];
  logic [DW-1:0] gather_c [LACE_NUM_WIDTHS][NCNT];

  for (genvar w = 0; w < LACE_NUM_WIDTHS; w++) begin : g_w
    for (genvar c = 0; c < NCNT; c++) begin : g_c
      lace_perm_net #(
        .ELEM_W  (lace_elem_bits(w)),
        .NREGS   (c + 2),
        .REG_W   (REG_W),
        .MAX_REGS(MAX_REGS)
      ) net_i (
        .data_i  (data_i),
        .spread_o(spread_c[w][c]),
        .gather_o(gather_c[w][c])
      );
    end
  end

  always_comb begin
    perm_o = '0;
    if (int'(cnt_idx_i) < NCNT) begin
      if (mode_i == LACE_GATHER) perm_o = gather_c[size_i][cnt_idx_i];
      else                       perm_o = spread_c[size_i][cnt_idx_i];
    end
  end

endmodule

// File: rtl/vec_lace_permuter.sv
module vec_lace_permuter
  import lace_pkg::*;
#(
  parameter int REG_W    = 64,
  parameter int MAX_REGS = 4,
  parameter int CNT_W    = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic                      in_mode,
  input  logic [1:0]                in_esize,
  input  logic [CNT_W-1:0]          in_nregs,
  input  logic [REG_W*MAX_REGS-1:0] in_data,
  output logic                      out_valid,
  output logic [REG_W*MAX_REGS-1:0] out_data
);
  localparam int DW = REG_W * MAX_REGS;

  logic [1:0]    cnt_idx;
  logic [DW-1:0] perm;
  lace_mode_e    mode;

  // legal counts 2..MAX_REGS map to index 0..; anything else acts as 2
  always_comb begin
    cnt_idx = 2'd0;
    if (int'(in_nregs) >= 3 && int'(in_nregs) <= MAX_REGS)
      cnt_idx = 2'(int'(in_nregs) - 2);
  end

  assign mode = lace_mode_e'(in_mode);

  lace_perm_bank #(
    .REG_W   (REG_W),
    .MAX_REGS(MAX_REGS)
  ) bank_i (
    .data_i   (in_data),
    .mode_i   (mode),
    .size_i   (in_esize),
    .cnt_idx_i(cnt_idx),
    .perm_o   (perm)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= perm;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_no_valid_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

  assert_two_reg_upper_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cnt_idx == 2'd0) |=> (out_data[DW-1:2*REG_W] == '0));

endmodule

// File: tb/vec_lace_permuter_tb_top.sv
`timescale 1ns/1ps
module vec_lace_permuter_tb_top;
  localparam int DW = 256;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic          in_mode;
  logic [1:0]    in_esize;
  logic [2:0]    in_nregs;
  logic [DW-1:0] in_data;
  logic          out_valid;
  logic [DW-1:0] out_data;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  vec_lace_permuter dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
    .in_esize(in_esize), .in_nregs(in_nregs), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected result from the lane/register description
  function automatic logic [DW-1:0] model(input logic mode, input int r, input int esz,
                                           input logic [DW-1:0] d);
    logic [DW-1:0] res = '0;
    int e = 8 << esz;
    int per = 64 / e;
    for (int reg_n = 0; reg_n < r; reg_n++)
      for (int lane = 0; lane < per; lane++) begin
        int k   = lane * r + reg_n;
        int pos = reg_n * per + lane;
        for (int b = 0; b < e; b++)
          if (!mode) res[pos*e + b] = d[k*e + b];
          else       res[k*e + b]   = d[pos*e + b];
      end
    return res;
  endfunction

  function automatic logic [DW-1:0] rnd256();
    return {$urandom(), $urandom(), $urandom(), $urandom(),
            $urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  function automatic logic [DW-1:0] low_mask(input int r);
    logic [DW-1:0] m = '0;
    for (int b = 0; b < 64 * r; b++) m[b] = 1'b1;
    return m;
  endfunction

  task automatic apply(input logic mode, input logic [1:0] esz, input logic [2:0] nr,
                       input logic [DW-1:0] d, output logic [DW-1:0] res);
    @(negedge clk);
    in_valid = 1'b1; in_mode = mode; in_esize = esz; in_nregs = nr; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
    res = out_data;
  endtask

  task automatic test_reset();
    logic [DW-1:0] r;
    apply(1'b0, 2'd0, 3'd4, {DW{1'b1}}, r);
    rst = 1'b1;
    @(negedge clk);
    check("R1 out_valid", {255'b0, out_valid}, '0);
    check("R1 out_data", out_data, '0);
    rst = 1'b0;
  endtask

  task automatic test_latency();
    @(negedge clk);
    in_valid = 1'b1; in_mode = 1'b0; in_esize = 2'd1; in_nregs = 3'd2; in_data = rnd256();
    #1;
    check("R2 low before edge", {255'b0, out_valid}, '0);
    @(negedge clk);
    check("R2 high after edge", {255'b0, out_valid}, {255'b0, 1'b1});
    in_valid = 1'b0;
    @(negedge clk);
    check("R2 low after idle", {255'b0, out_valid}, '0);
  endtask

  task automatic test_spread_bytes();
    logic [DW-1:0] d = '0, r, e = '0;
    for (int i = 0; i < 32; i++) d[i*8 +: 8] = 8'(i);
    // 2 regs, bytes: reg0 gets even bytes, reg1 odd bytes
    for (int l = 0; l < 8; l++) begin
      e[l*8 +: 8]      = 8'(2*l);
      e[64 + l*8 +: 8] = 8'(2*l + 1);
    end
    apply(1'b0, 2'd0, 3'd2, d, r);
    check("R3 spread bytes x2", r, e);
  endtask

  task automatic test_gather_words();
    logic [DW-1:0] d = '0, r, e = '0;
    // 3 regs of 16-bit: register r lane l holds value 16*r+l
    for (int rg = 0; rg < 3; rg++)
      for (int l = 0; l < 4; l++) d[rg*64 + l*16 +: 16] = 16'(16*rg + l);
    for (int k = 0; k < 12; k++) e[k*16 +: 16] = 16'(16*(k % 3) + k / 3);
    apply(1'b1, 2'd1, 3'd3, d, r);
    check("R4 gather halfwords x3", r, e);
  endtask

  task automatic test_all_modes();
    logic [DW-1:0] d, r;
    for (int nr = 2; nr <= 4; nr++)
      for (int es = 0; es < 4; es++)
        for (int m = 0; m < 2; m++) begin
          d = rnd256();
          apply(m[0], 2'(es), 3'(nr), d, r);
          check(m ? "R4 R5 gather sweep" : "R3 R5 spread sweep", r, model(m[0], nr, es, d));
        end
  endtask

  task automatic test_count_alias();
    logic [DW-1:0] d, r;
    int odd_counts [4] = '{0, 1, 5, 7};
    foreach (odd_counts[i]) begin
      d = rnd256();
      apply(1'b0, 2'd0, 3'(odd_counts[i]), d, r);
      check("R6 count alias to 2", r, model(1'b0, 2, 0, d));
    end
  endtask

  task automatic test_upper_zero_ignore();
    logic [DW-1:0] d, r1, r2;
    for (int nr = 2; nr <= 3; nr++) begin
      d = rnd256() & low_mask(nr);
      apply(1'b1, 2'd2, 3'(nr), d, r1);
      check("R7 upper zero", r1 & ~low_mask(nr), '0);
      apply(1'b1, 2'd2, 3'(nr), d | ~low_mask(nr), r2);
      check("R8 upper input ignored", r2, r1);
    end
  endtask

  task automatic test_hold();
    logic [DW-1:0] r;
    apply(1'b0, 2'd3, 3'd4, rnd256(), r);
    for (int i = 0; i < 3; i++) begin
      in_data = rnd256(); in_mode = ~in_mode;
      @(negedge clk);
      check("R9 hold while idle", out_data, r);
    end
  endtask

  task automatic test_roundtrip();
    logic [DW-1:0] d, s, g;
    for (int nr = 2; nr <= 4; nr++)
      for (int es = 0; es < 4; es++) begin
        d = rnd256();
        apply(1'b0, 2'(es), 3'(nr), d, s);
        apply(1'b1, 2'(es), 3'(nr), s, g);
        check("R10 round trip", g, d & low_mask(nr));
      end
  endtask

  task automatic test_wide_identity();
    logic [DW-1:0] d, r;
    for (int nr = 2; nr <= 4; nr++)
      for (int m = 0; m < 2; m++) begin
        d = rnd256();
        apply(m[0], 2'd3, 3'(nr), d, r);
        check("R11 64-bit identity", r, d & low_mask(nr));
      end
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_mode = 1'b0; in_esize = 2'd0;
    in_nregs = 3'd2; in_data = '0;
    repeat (3) @(negedge clk);
    check("R1 after power-up reset", {out_valid, out_data[254:0]}, '0);
    rst = 1'b0;
    test_latency();
    test_spread_bytes();
    test_gather_words();
    test_all_modes();
    test_count_alias();
    test_upper_zero_ignore();
    test_hold();
    test_roundtrip();
    test_wide_identity();
    test_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule